// File: doc/BRIEF.md
# Byte-Serial Handshaked Register Slave

This block sits in an FPGA and gives an external microcontroller read and write access to a bank of 32-bit registers through an 8-bit data path. The host controls each transfer with a start line, a direction line and a strobe (`host_hs1`). The slave answers each byte with its own strobe (`host_hs2`). All host control lines are asynchronous, so they pass through synchronisers before the sequencer acts on them.

A transaction starts when the host raises start. The host then sends six bytes in this order: a command byte, a register-number byte and four data bytes. The slave performs the access. It then returns eight bytes: a 32-bit data word followed by a 32-bit status word. After the last reply byte the slave raises acknowledge and holds it until the host drops start.

Register numbers fall into three windows, one each for motor-PWM, encoder and servo registers. Addresses outside the windows are rejected. The bidirectional pad is split into `bus_in`, `bus_out` and the enable `bus_oe`.

Top module: `hsr_slave`

## Requirements
- R1: After `rst`, `bus_oe`, `host_hs2` and `host_ack` are 0. A host reset seen through the synchroniser also forces all three to 0 within four clock cycles.
- R2: Each byte uses a four-phase handshake. `host_hs2` rises only after the synchronised `host_hs1` has been seen high. It falls only after `host_hs1` has been seen low. A strobe is accepted in the receive phase only while `host_rw` is 1, and in the reply phase only while `host_rw` is 0.
- R3: `bus_oe` is 0 throughout the six-byte receive phase and while `host_ack` is high. It is 1 only during the reply bytes.
- R4: Command byte 1 writes the 32-bit value to the addressed register; the four data bytes are sent least-significant byte first. Command byte 0 reads the register, and the reply data word returns its content.
- R5: The reply is eight bytes, sent in this order: the data word least-significant byte first, then the status word least-significant byte first.
- R6: The reply data word for a write holds the register's content from before the write.
- R7: For a mapped address, status bits 9:8 give the window and all other status bits are 0. The window codes are: 1 for addresses 1 to 16, 2 for addresses 17 to 44, and 3 for addresses 45 to 76.
- R8: Address 0 and addresses above 76 are unmapped. For these, status bit 0 is 1, the data word is 0, and a write changes no register.
- R9: A command byte other than 0 or 1 sets status bit 1 and writes nothing.
- R10: `host_ack` rises when `host_hs2` falls after the eighth reply byte. It stays high until start is seen low, then returns to 0.
- R11: A host reset in the middle of a transaction returns the slave to idle, and the next complete transaction behaves normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rw | input | 1 | Direction: 1 means the host drives, 0 means the slave drives (asynchronous) |
| host_start | input | 1 | Transaction frame (asynchronous) |
| host_hs1 | input | 1 | Host byte strobe (asynchronous) |
| host_reset | input | 1 | Host-side reset request (asynchronous) |
| bus_in | input | 8 | Byte from the pad input |
| bus_out | output | 8 | Byte to the pad output |
| bus_oe | output | 1 | Pad output enable |
| host_ack | output | 1 | Transaction complete |
| host_hs2 | output | 1 | Slave byte strobe |

## Verification
The assertions check on every cycle that handshake order is kept:
- the slave strobe never rises without a synchronised host strobe before it, and never falls while that strobe is still high;
- the pad is never driven while acknowledge is high;
- a host reset clears the outputs;
- acknowledge only drops after start goes low;
- no write reaches the bank at an unmapped address.

Only the bench scenarios can show the rest. These cover the byte order of the assembled words and the reply, the read-before-write echo, the window codes at each window edge, the status of rejected commands, and recovery from a reset that arrives partway through a packet.

// File: rtl/hsr_pkg.sv
package hsr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RX_REL, ST_EXEC, ST_LOAD, ST_TX, ST_TX_REL, ST_DONE
  } hsr_state_t;

  localparam logic [7:0] CMD_READ  = 8'd0;
  localparam logic [7:0] CMD_WRITE = 8'd1;
  localparam int RX_BYTES = 6;
  localparam int TX_BYTES = 8;
endpackage

// File: rtl/hsr_sync.sv
module hsr_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= '0;
    else     stage[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[s] <= '0;
      else     stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/hsr_regbank.sv
module hsr_regbank #(
  parameter int PWM_BASE = 1,
  parameter int PWM_CH   = 4,
  parameter int PWM_REGS = 4,
  parameter int QE_CH    = 4,
  parameter int QE_REGS  = 7,
  parameter int RC_CH    = 8,
  parameter int RC_REGS  = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  addr,
  input  logic        we,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        mapped,
  output logic [1:0]  window
);
  localparam int QE_BASE = PWM_BASE + PWM_CH * PWM_REGS;
  localparam int RC_BASE = QE_BASE + QE_CH * QE_REGS;
  localparam int END_ADR = RC_BASE + RC_CH * RC_REGS;
  localparam int DEPTH   = END_ADR - PWM_BASE;
  localparam int AW      = $clog2(DEPTH);

  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] idx;
  int            a;

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_comb begin
    a      = int'(addr);
    mapped = (a >= PWM_BASE) && (a < END_ADR);
    if (a >= PWM_BASE && a < QE_BASE)      window = 2'd1;
    else if (a >= QE_BASE && a < RC_BASE)  window = 2'd2;
    else if (a >= RC_BASE && a < END_ADR)  window = 2'd3;
    else                                   window = 2'd0;
    idx = mapped ? AW'(a - PWM_BASE) : '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    rdata <= mem[idx];
  end

  assert_wr_mapped_R8: assert property (@(posedge clk) disable iff (rst)
    we |-> mapped);
endmodule

// File: rtl/hsr_slave.sv
module hsr_slave
  import hsr_pkg::*;
#(
  parameter int PWM_BASE    = 1,
  parameter int PWM_CH      = 4,
  parameter int PWM_REGS    = 4,
  parameter int QE_CH       = 4,
  parameter int QE_REGS     = 7,
  parameter int RC_CH       = 8,
  parameter int RC_REGS     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       host_rw,
  input  logic       host_start,
  input  logic       host_hs1,
  input  logic       host_reset,
  input  logic [7:0] bus_in,
  output logic [7:0] bus_out,
  output logic       bus_oe,
  output logic       host_ack,
  output logic       host_hs2
);
  localparam int CW = $clog2(TX_BYTES);

  logic       rw_s, start_s, hs1_s, rst_s;
  hsr_state_t st;
  logic [CW-1:0] cnt;
  logic [7:0]  cmd, regno;
  logic [31:0] wdat, rdata;
  logic [63:0] reply;
  logic        mapped, bank_we, bad_cmd;
  logic [1:0]  window;
  logic [31:0] status;

  hsr_sync #(.W(4), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk), .rst (rst),
    .d   ({host_reset, host_hs1, host_start, host_rw}),
    .q   ({rst_s, hs1_s, start_s, rw_s})
  );

  assign bad_cmd = (cmd != CMD_READ) && (cmd != CMD_WRITE);
  assign bank_we = (st == ST_EXEC) && (cmd == CMD_WRITE) && mapped;
  assign status  = {22'd0, window, 6'd0, bad_cmd, ~mapped};

  hsr_regbank #(
    .PWM_BASE(PWM_BASE), .PWM_CH(PWM_CH), .PWM_REGS(PWM_REGS),
    .QE_CH(QE_CH), .QE_REGS(QE_REGS), .RC_CH(RC_CH), .RC_REGS(RC_REGS)
  ) i_bank (
    .clk (clk), .rst (rst), .addr (regno), .we (bank_we), .wdata (wdat),
    .rdata (rdata), .mapped (mapped), .window (window)
  );

  always_ff @(posedge clk) begin
    if (rst || rst_s) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      host_hs2 <= 1'b0;
      host_ack <= 1'b0;
      bus_oe   <= 1'b0;
      bus_out  <= '0;
      cmd      <= '0;
      regno    <= '0;
      wdat     <= '0;
      reply    <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start_s) begin
          cnt <= '0;
          st  <= ST_RX;
        end
        ST_RX: if (hs1_s && rw_s) begin
          if (cnt == 0)      cmd   <= bus_in;
          else if (cnt == 1) regno <= bus_in;
          else               wdat  <= {bus_in, wdat[31:8]};
          host_hs2 <= 1'b1;
          st       <= ST_RX_REL;
        end
        ST_RX_REL: if (!hs1_s) begin
          host_hs2 <= 1'b0;
          if (cnt == CW'(RX_BYTES - 1)) st <= ST_EXEC;
          else begin
            cnt <= cnt + 1'b1;
            st  <= ST_RX;
          end
        end
        ST_EXEC: st <= ST_LOAD;
        ST_LOAD: begin
          reply   <= {status, (mapped ? rdata : 32'd0)};
          bus_out <= mapped ? rdata[7:0] : 8'd0;
          bus_oe  <= 1'b1;
          cnt     <= '0;
          st      <= ST_TX;
        end
        ST_TX: if (hs1_s && !rw_s) begin
          host_hs2 <= 1'b1;
          st       <= ST_TX_REL;
        end
        ST_TX_REL: if (!hs1_s) begin
          host_hs2 <= 1'b0;
          if (cnt == CW'(TX_BYTES - 1)) begin
            host_ack <= 1'b1;
            bus_oe   <= 1'b0;
            st       <= ST_DONE;
          end else begin
            cnt     <= cnt + 1'b1;
            reply   <= reply >> 8;
            bus_out <= reply[15:8];
            st      <= ST_TX;
          end
        end
        ST_DONE: if (!start_s) begin
          host_ack <= 1'b0;
          st       <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_hs2_rise_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(host_hs2) |-> $past(hs1_s));
  assert_hs2_fall_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(host_hs2) |-> (!$past(hs1_s) || $past(rst_s)));
  assert_no_drive_ack_R3: assert property (@(posedge clk) disable iff (rst)
    host_ack |-> !bus_oe);
  assert_host_reset_R1: assert property (@(posedge clk) disable iff (rst)
    rst_s |=> (!bus_oe && !host_hs2 && !host_ack));
  assert_ack_hold_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(host_ack) |-> (!$past(start_s) || $past(rst_s)));
endmodule

// File: tb/test_hsr_slave.sv
module test_hsr_slave;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_rw = 1'b0, host_start = 1'b0, host_hs1 = 1'b0, host_reset = 1'b0;
  logic [7:0] bus_in = '0;
  logic [7:0] bus_out;
  logic       bus_oe, host_ack, host_hs2;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  typedef struct { logic [7:0] val; string tag; int idx; } exp_t;
  exp_t exp_q[$];
  logic [31:0] model [256];

  always #5 clk = ~clk;

  hsr_slave i_hsr_slave (
    .clk(clk), .rst(rst), .host_rw(host_rw), .host_start(host_start),
    .host_hs1(host_hs1), .host_reset(host_reset), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .host_ack(host_ack), .host_hs2(host_hs2)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare each reply byte as the slave strobe rises
  logic hs2_prev = 1'b0;
  always @(negedge clk) begin
    if (host_hs2 && !hs2_prev && bus_oe) begin
      if (exp_q.size() == 0) chk(1'b0, "R5 unexpected reply byte", {24'd0, bus_out}, 32'd0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(bus_out === e.val, $sformatf("%s byte%0d", e.tag, e.idx), {24'd0, bus_out}, {24'd0, e.val});
      end
    end
    hs2_prev = host_hs2;
  end

  task automatic wait_hs2(input logic v);
    while (host_hs2 !== v) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    host_rw = 1'b1;
    bus_in  = b;
    @(negedge clk);
    host_hs1 = 1'b1;
    @(negedge clk);
    chk(host_hs2 === 1'b0, "R2 hs2 early", {31'd0, host_hs2}, 32'd0);
    wait_hs2(1'b1);
    chk(bus_oe === 1'b0, "R3 oe during receive", {31'd0, bus_oe}, 32'd0);
    host_hs1 = 1'b0;
    wait_hs2(1'b0);
  endtask

  task automatic recv_byte();
    @(negedge clk);
    host_rw  = 1'b0;
    host_hs1 = 1'b1;
    wait_hs2(1'b1);
    @(negedge clk);
    host_hs1 = 1'b0;
    wait_hs2(1'b0);
  endtask

  task automatic transact(input logic [7:0] cmd, input logic [7:0] adr, input logic [31:0] d, input string tag);
    bit mapped;
    logic [1:0] win;
    logic [31:0] dat, st;
    mapped = (adr >= 1) && (adr <= 76);
    win = (adr >= 1 && adr <= 16) ? 2'd1 : (adr >= 17 && adr <= 44) ? 2'd2 :
          (adr >= 45 && adr <= 76) ? 2'd3 : 2'd0;
    dat = mapped ? model[adr] : 32'd0;
    st  = {22'd0, win, 6'd0, (cmd > 8'd1), ~mapped};
    for (int i = 0; i < 4; i++) exp_q.push_back('{dat[8*i +: 8], {tag, " data"}, i});
    for (int i = 0; i < 4; i++) exp_q.push_back('{st[8*i +: 8], {tag, " status"}, i + 4});
    if (cmd == 8'd1 && mapped) model[adr] = d;
    @(negedge clk);
    host_rw = 1'b1;
    host_start = 1'b1;
    send_byte(cmd);
    send_byte(adr);
    for (int i = 0; i < 4; i++) send_byte(d[8*i +: 8]);
    for (int i = 0; i < 8; i++) recv_byte();
    chk(host_ack === 1'b1, "R10 ack after last byte", {31'd0, host_ack}, 32'd1);
    chk(exp_q.size() == 0, "R5 reply byte count", exp_q.size(), 32'd0);
    exp_q.delete();
    repeat (4) @(negedge clk);
    chk(host_ack === 1'b1, "R10 ack held", {31'd0, host_ack}, 32'd1);
    host_start = 1'b0;
    repeat (5) @(negedge clk);
    chk(host_ack === 1'b0, "R10 ack cleared", {31'd0, host_ack}, 32'd0);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({bus_oe, host_hs2, host_ack} === 3'b000, "R1 reset outputs", {29'd0, bus_oe, host_hs2, host_ack}, 32'd0);

    // R4 R6 R7: writes across each window edge, then readback
    transact(8'd1, 8'd1,  32'h11223344, "R4 R7 write a1");
    transact(8'd0, 8'd1,  32'h0,        "R4 R5 read a1");
    transact(8'd1, 8'd16, 32'hA5A50016, "R7 write a16");
    transact(8'd1, 8'd17, 32'h00170017, "R7 write a17");
    transact(8'd1, 8'd44, 32'hDEAD0044, "R7 write a44");
    transact(8'd1, 8'd45, 32'hBEEF0045, "R7 write a45");
    transact(8'd1, 8'd76, 32'hCAFE0076, "R7 write a76");
    transact(8'd0, 8'd16, 32'h0, "R4 read a16");
    transact(8'd0, 8'd17, 32'h0, "R4 read a17");
    transact(8'd0, 8'd45, 32'h0, "R4 read a45");
    transact(8'd1, 8'd1,  32'hFFEE0001, "R6 overwrite a1");
    transact(8'd0, 8'd1,  32'h0, "R6 read a1");

    // R8 unmapped
    transact(8'd1, 8'd0,   32'h12345678, "R8 write a0");
    transact(8'd1, 8'd77,  32'h87654321, "R8 write a77");
    transact(8'd0, 8'd200, 32'h0, "R8 read a200");
    transact(8'd0, 8'd76,  32'h0, "R8 a76 untouched");

    // R9 bad command
    transact(8'd5, 8'd2, 32'h55555555, "R9 bad cmd a2");
    transact(8'd0, 8'd2, 32'h0, "R9 a2 unwritten");

    // R2: strobe ignored while direction says slave drives
    @(negedge clk);
    host_start = 1'b1;
    host_rw = 1'b0;
    host_hs1 = 1'b1;
    repeat (10) @(negedge clk);
    chk(host_hs2 === 1'b0, "R2 strobe ignored with rw=0", {31'd0, host_hs2}, 32'd0);
    host_hs1 = 1'b0;

    // R11: host reset mid-packet
    send_byte(8'd1);
    send_byte(8'd3);
    host_reset = 1'b1;
    repeat (3) @(negedge clk);
    host_reset = 1'b0;
    host_start = 1'b0;
    repeat (5) @(negedge clk);
    chk({bus_oe, host_hs2, host_ack} === 3'b000, "R1 R11 host reset outputs", {29'd0, bus_oe, host_hs2, host_ack}, 32'd0);
    transact(8'd0, 8'd1, 32'h0, "R11 recovery read a1");
    transact(8'd0, 8'd3, 32'h0, "R11 a3 unwritten");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule